// File: doc/BRIEF.md
# Interrupt Redirection and Delivery Controller

This block collects interrupt requests from a bank of input pins and turns them into delivery messages for the processors. Each pin owns a redirection entry that sets the message vector, delivery mode, destination mode, destination byte and trigger mode, together with a mask bit. The block also keeps a pending flag and a remote-acknowledge flag for each pin. Outside logic programs the entries through a 32-bit half-entry write port.

Eligible pins are scanned from the lowest index upward. The block sends at most one message per cycle on a valid/ready output stream. Level-triggered pins take part in an acknowledge handshake: once such a pin is delivered, it stays blocked until an end-of-interrupt notice with the same vector arrives. Edge requests that arrive while a pin is masked are lost. Logical input 0 is redirected onto pin 2. For entries that use the external-interrupt delivery mode, the vector is taken from a side input instead of from the entry.

Top module: `irq_route_ctrl`

## Requirements
- R1: After reset every entry is masked, edge-triggered and zero in all other fields, and no pin is pending, so `msg_valid` is 0 and toggling inputs delivers nothing.
- R2: A write with `wr_upper`=0 loads vector from `wr_data[7:0]`, delivery mode from `[10:8]`, destination mode from `[11]`, trigger mode from `[15]` (1 = level) and mask from `[16]`. A write with `wr_upper`=1 loads the destination from `wr_data[31:24]`. The delivered message carries these values.
- R3: Activity on input 0 acts on pin 2, and the entry of pin 0 never produces a message.
- R4: A rising edge on an unmasked edge-triggered pin produces exactly one message, because delivery clears the pending flag.
- R5: A rising edge on a masked edge-triggered pin is dropped, so unmasking the pin later delivers nothing.
- R6: A level-triggered pin whose input is high is delivered once, with `msg_trig`=1. It is then held back until a matching end-of-interrupt. If the input goes low before that notice, the pending flag clears and the notice causes no delivery.
- R7: An end-of-interrupt whose vector matches a level entry clears its acknowledge flag, and the pin is delivered again if it is still pending and unmasked. A notice with a different vector has no effect.
- R8: Several eligible pins are delivered in ascending pin order, one per cycle while `msg_ready` is high.
- R9: While `msg_valid` is high and `msg_ready` is low, every message field holds its value.
- R10: An entry whose delivery mode is 3'b111 sends `ext_vector` as its vector.
- R11: A pending level pin that is masked is not delivered, and a write that clears its mask causes a delivery.
- R12: When an end-of-interrupt with a pin's vector lands in the same cycle that the pin is delivered, the new acknowledge flag wins and the pin is not delivered again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pin_in | input | NUM_PINS | Interrupt input levels |
| wr_en | input | 1 | Entry write strobe |
| wr_sel | input | IDX_W | Entry index to write |
| wr_upper | input | 1 | 0 = lower half, 1 = upper half |
| wr_data | input | 32 | Half-entry write data |
| ext_vector | input | 8 | Vector used for the external-interrupt mode |
| eoi_valid | input | 1 | End-of-interrupt notice strobe |
| eoi_vector | input | 8 | Vector of the notice |
| msg_valid | output | 1 | Message available |
| msg_ready | input | 1 | Consumer accepts the message |
| msg_dest | output | 8 | Destination |
| msg_dest_mode | output | 1 | Destination mode |
| msg_deliv_mode | output | 3 | Delivery mode |
| msg_vector | output | 8 | Vector |
| msg_trig | output | 1 | Trigger mode (1 = level) |

## Verification
Two events can fall in the same cycle: a level pin being loaded into the output register, and an end-of-interrupt carrying that pin's vector. The bench sets this up by stalling the stream with an earlier message while a level pin waits as pending. It then raises `msg_ready` and the notice on the same edge. With the input still held high, the pin must appear exactly once. A further notice must then release it one more time.

// File: rtl/irq_route_pkg.sv
package irq_route_pkg;
  localparam int VEC_W  = 8;
  localparam int DM_W   = 3;
  localparam int DEST_W = 8;

  // bit positions inside a 32-bit half-entry write
  localparam int LO_VEC_LSB  = 0;
  localparam int LO_DM_LSB   = 8;
  localparam int LO_DMODE    = 11;
  localparam int LO_LEVEL    = 15;
  localparam int LO_MASK     = 16;
  localparam int HI_DEST_LSB = 24;

  localparam logic [DM_W-1:0] DM_EXTERNAL = 3'b111;

  typedef struct packed {
    logic [DEST_W-1:0] dest;
    logic              mask;
    logic              level;
    logic              dmode;
    logic [DM_W-1:0]   dm;
    logic [VEC_W-1:0]  vector;
  } rte_t;

  localparam rte_t RTE_RESET = '{dest: '0, mask: 1'b1, level: 1'b0,
                                 dmode: 1'b0, dm: '0, vector: '0};
endpackage

// File: rtl/irq_pin_slot.sv
module irq_pin_slot
  import irq_route_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             level_in,
  input  logic             wr_lo,
  input  logic             wr_hi,
  input  logic [31:0]      wr_data,
  input  logic             eoi_valid,
  input  logic [VEC_W-1:0] eoi_vector,
  input  logic             take,
  output rte_t             cfg,
  output logic             eligible
);
  rte_t cfg_q, cfg_d;
  logic cfg_en;
  logic pend_q, pend_d;
  logic ack_q, ack_d;
  logic prev_q;
  logic rise;

  always_comb begin
    cfg_d  = cfg_q;
    cfg_en = wr_lo | wr_hi;
    if (wr_lo) begin
      cfg_d.vector = wr_data[LO_VEC_LSB +: VEC_W];
      cfg_d.dm     = wr_data[LO_DM_LSB +: DM_W];
      cfg_d.dmode  = wr_data[LO_DMODE];
      cfg_d.level  = wr_data[LO_LEVEL];
      cfg_d.mask   = wr_data[LO_MASK];
    end
    if (wr_hi) cfg_d.dest = wr_data[HI_DEST_LSB +: DEST_W];

    rise = level_in & ~prev_q;
    if (cfg_q.level) pend_d = level_in;
    else             pend_d = (pend_q & ~take) | (rise & ~cfg_q.mask);

    ack_d = ack_q;
    if (eoi_valid && ack_q && (eoi_vector == cfg_q.vector)) ack_d = 1'b0;
    if (take && cfg_q.level) ack_d = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cfg_q <= RTE_RESET;
    end else if (cfg_en) begin
      cfg_q <= cfg_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_q <= 1'b0;
      ack_q  <= 1'b0;
      prev_q <= 1'b0;
    end else begin
      pend_q <= pend_d;
      ack_q  <= ack_d;
      prev_q <= level_in;
    end
  end

  assign cfg      = cfg_q;
  assign eligible = pend_q & ~cfg_q.mask & ~(cfg_q.level & ack_q);
endmodule

// File: rtl/irq_lowest_pick.sv
module irq_lowest_pick #(
  parameter int N    = 24,
  parameter int IW   = $clog2(N)
) (
  input  logic [N-1:0]  req,
  output logic          any,
  output logic [IW-1:0] idx,
  output logic [N-1:0]  grant
);
  always_comb begin
    any   = 1'b0;
    idx   = '0;
    grant = '0;
    for (int i = 0; i < N; i++) begin
      if (req[i] && !any) begin
        any      = 1'b1;
        idx      = IW'(i);
        grant[i] = 1'b1;
      end
    end
  end
endmodule

// File: rtl/irq_route_ctrl.sv
module irq_route_ctrl
  import irq_route_pkg::*;
#(
  parameter int NUM_PINS = 24,
  parameter int FOLD_SRC = 0,
  parameter int FOLD_DST = 2,
  localparam int IDX_W   = $clog2(NUM_PINS)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [NUM_PINS-1:0] pin_in,
  input  logic              wr_en,
  input  logic [IDX_W-1:0]  wr_sel,
  input  logic              wr_upper,
  input  logic [31:0]       wr_data,
  input  logic [VEC_W-1:0]  ext_vector,
  input  logic              eoi_valid,
  input  logic [VEC_W-1:0]  eoi_vector,
  output logic              msg_valid,
  input  logic              msg_ready,
  output logic [DEST_W-1:0] msg_dest,
  output logic              msg_dest_mode,
  output logic [DM_W-1:0]   msg_deliv_mode,
  output logic [VEC_W-1:0]  msg_vector,
  output logic              msg_trig
);
  logic [NUM_PINS-1:0] eff_in;
  logic [NUM_PINS-1:0] elig;
  logic [NUM_PINS-1:0] grant;
  logic [NUM_PINS-1:0] take;
  rte_t                cfg_a [NUM_PINS];
  logic                any;
  logic [IDX_W-1:0]    sel_idx;
  rte_t                sel_cfg;
  logic                sel_level;
  logic                load;

  // input folding: one logical input is steered onto another pin
  for (genvar g = 0; g < NUM_PINS; g++) begin : g_fold
    if (g == FOLD_SRC) begin : g_src
      assign eff_in[g] = 1'b0;
    end else if (g == FOLD_DST) begin : g_dst
      assign eff_in[g] = pin_in[g] | pin_in[FOLD_SRC];
    end else begin : g_dir
      assign eff_in[g] = pin_in[g];
    end
  end

  for (genvar g = 0; g < NUM_PINS; g++) begin : g_slot
    logic hit;
    assign hit     = wr_en && (wr_sel == IDX_W'(g));
    assign take[g] = load & grant[g];
    irq_pin_slot u_slot (
      .clk        (clk),
      .rst_n      (rst_n),
      .level_in   (eff_in[g]),
      .wr_lo      (hit & ~wr_upper),
      .wr_hi      (hit & wr_upper),
      .wr_data    (wr_data),
      .eoi_valid  (eoi_valid),
      .eoi_vector (eoi_vector),
      .take       (take[g]),
      .cfg        (cfg_a[g]),
      .eligible   (elig[g])
    );
  end

  irq_lowest_pick #(.N(NUM_PINS), .IW(IDX_W)) u_pick (
    .req   (elig),
    .any   (any),
    .idx   (sel_idx),
    .grant (grant)
  );

  // output stage: next-state logic
  logic              valid_q, valid_d, data_en;
  logic [DEST_W-1:0] dest_q;
  logic              dmode_q, trig_q;
  logic [DM_W-1:0]   dm_q;
  logic [VEC_W-1:0]  vec_q, vec_d;

  always_comb begin
    sel_cfg   = cfg_a[sel_idx];
    sel_level = sel_cfg.level;
    load      = ~valid_q | msg_ready;
    valid_d   = load ? any : valid_q;
    data_en   = load & any;
    vec_d     = (sel_cfg.dm == DM_EXTERNAL) ? ext_vector : sel_cfg.vector;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) valid_q <= 1'b0;
    else        valid_q <= valid_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dest_q  <= '0;
      dmode_q <= 1'b0;
      dm_q    <= '0;
      vec_q   <= '0;
      trig_q  <= 1'b0;
    end else if (data_en) begin
      dest_q  <= sel_cfg.dest;
      dmode_q <= sel_cfg.dmode;
      dm_q    <= sel_cfg.dm;
      vec_q   <= vec_d;
      trig_q  <= sel_cfg.level;
    end
  end

  assign msg_valid      = valid_q;
  assign msg_dest       = dest_q;
  assign msg_dest_mode  = dmode_q;
  assign msg_deliv_mode = dm_q;
  assign msg_vector     = vec_q;
  assign msg_trig       = trig_q;
endmodule

// File: rtl/irq_route_chk.sv
module irq_route_chk #(
  parameter int NUM_PINS = 24,
  parameter int IDX_W    = $clog2(NUM_PINS)
) (
  input logic                clk,
  input logic                rst_n,
  input logic                msg_valid,
  input logic                msg_ready,
  input logic [7:0]          msg_dest,
  input logic                msg_dest_mode,
  input logic [2:0]          msg_deliv_mode,
  input logic [7:0]          msg_vector,
  input logic                msg_trig,
  input logic [NUM_PINS-1:0] elig,
  input logic [NUM_PINS-1:0] grant,
  input logic                load,
  input logic                sel_level,
  input logic                wr_en
);
  // R9
  stall_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (msg_valid && !msg_ready) |=> (msg_valid && $stable(msg_vector) &&
      $stable(msg_dest) && $stable(msg_dest_mode) &&
      $stable(msg_deliv_mode) && $stable(msg_trig)));

  // R8
  single_grant_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(grant));

  // R8
  lowest_first_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (load && (|grant)) |-> ((elig & (grant - 1'b1)) == '0));

  // R6
  level_block_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (load && (|grant) && sel_level && !wr_en) |=> ((elig & $past(grant)) == '0));

  // R1
  valid_source_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(msg_valid) |-> $past(|elig));
endmodule

bind irq_route_ctrl irq_route_chk #(.NUM_PINS(NUM_PINS)) u_route_chk (
  .clk            (clk),
  .rst_n          (rst_n),
  .msg_valid      (msg_valid),
  .msg_ready      (msg_ready),
  .msg_dest       (msg_dest),
  .msg_dest_mode  (msg_dest_mode),
  .msg_deliv_mode (msg_deliv_mode),
  .msg_vector     (msg_vector),
  .msg_trig       (msg_trig),
  .elig           (elig),
  .grant          (grant),
  .load           (load),
  .sel_level      (sel_level),
  .wr_en          (wr_en)
);

// File: tb/test_irq_route_ctrl.sv
module test_irq_route_ctrl;
  localparam int N  = 24;
  localparam int IW = $clog2(N);

  logic          clk = 1'b0;
  logic          rst_n;
  logic [N-1:0]  pin_in;
  logic          wr_en, wr_upper;
  logic [IW-1:0] wr_sel;
  logic [31:0]   wr_data;
  logic [7:0]    ext_vector;
  logic          eoi_valid;
  logic [7:0]    eoi_vector;
  logic          msg_valid, msg_ready;
  logic [7:0]    msg_dest, msg_vector;
  logic          msg_dest_mode, msg_trig;
  logic [2:0]    msg_deliv_mode;

  always #5 clk = ~clk;

  irq_route_ctrl #(.NUM_PINS(N)) i_irq_route_ctrl (
    .clk(clk), .rst_n(rst_n), .pin_in(pin_in), .wr_en(wr_en), .wr_sel(wr_sel),
    .wr_upper(wr_upper), .wr_data(wr_data), .ext_vector(ext_vector),
    .eoi_valid(eoi_valid), .eoi_vector(eoi_vector), .msg_valid(msg_valid),
    .msg_ready(msg_ready), .msg_dest(msg_dest), .msg_dest_mode(msg_dest_mode),
    .msg_deliv_mode(msg_deliv_mode), .msg_vector(msg_vector), .msg_trig(msg_trig));

  int checks = 0;
  int errors = 0;
  int cyc    = 0;
  bit done   = 1'b0;
  logic [20:0] rec_q[$];
  int          stamp_q[$];

  always @(posedge clk) cyc <= cyc + 1;

  // transfers are captured mid-cycle, before the edge that completes them
  always @(negedge clk) begin
    if (rst_n && msg_valid && msg_ready) begin
      rec_q.push_back({msg_dest, msg_dest_mode, msg_deliv_mode, msg_trig, msg_vector});
      stamp_q.push_back(cyc);
    end
  end

  function automatic logic [20:0] mk(input logic [7:0] dest, input logic dmode,
                                     input logic [2:0] dm, input logic trig,
                                     input logic [7:0] vec);
    return {dest, dmode, dm, trig, vec};
  endfunction

  task automatic tick(input int n = 1);
    repeat (n) begin
      @(posedge clk);
      #1;
    end
  endtask

  task automatic chk(input bit ok, input string tag, input logic [31:0] act,
                     input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
    end
  endtask

  task automatic wr_entry(input int idx, input logic [7:0] vec, input logic [2:0] dm,
                          input logic dmode, input logic lvl, input logic mask,
                          input logic [7:0] dest);
    wr_en = 1'b1; wr_sel = IW'(idx);
    wr_upper = 1'b1; wr_data = {dest, 24'h0};
    tick();
    wr_upper = 1'b0; wr_data = {15'h0, mask, lvl, 3'b000, dmode, dm, vec};
    tick();
    wr_en = 1'b0;
  endtask

  task automatic pulse(input int pin);
    pin_in[pin] = 1'b1;
    tick();
    pin_in[pin] = 1'b0;
  endtask

  task automatic eoi(input logic [7:0] v);
    eoi_valid = 1'b1; eoi_vector = v;
    tick();
    eoi_valid = 1'b0;
  endtask

  task automatic clearq();
    rec_q.delete();
    stamp_q.delete();
  endtask

  function automatic int nth_set(input logic [7:0] bits, input int k);
    int seen = 0;
    for (int b = 0; b < 8; b++) begin
      if (bits[b]) begin
        if (seen == k) return b;
        seen++;
      end
    end
    return -1;
  endfunction

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h5eed_1234));
    rst_n = 1'b0; pin_in = '0; wr_en = 1'b0; wr_upper = 1'b0; wr_sel = '0;
    wr_data = '0; ext_vector = 8'h9C; eoi_valid = 1'b0; eoi_vector = '0;
    msg_ready = 1'b1;
    tick(3);
    rst_n = 1'b1;
    tick(2);

    // R1: reset state and all-masked entries
    chk(msg_valid == 1'b0, "R1 reset valid", 32'(msg_valid), 0);
    pin_in = '1; tick(3); pin_in = '0; tick(6);
    chk(rec_q.size() == 0, "R1 masked after reset", rec_q.size(), 0);
    clearq();

    // R2 + R4: field layout and single edge delivery
    wr_entry(5, 8'h35, 3'b001, 1'b1, 1'b0, 1'b0, 8'hA5);
    pulse(5); tick(8);
    chk(rec_q.size() == 1, "R4 one edge delivery", rec_q.size(), 1);
    if (rec_q.size() > 0)
      chk(rec_q[0] == mk(8'hA5, 1'b1, 3'b001, 1'b0, 8'h35), "R2 fields",
          32'(rec_q[0]), 32'(mk(8'hA5, 1'b1, 3'b001, 1'b0, 8'h35)));
    clearq();

    // R5: masked edge discarded
    wr_entry(5, 8'h35, 3'b001, 1'b1, 1'b0, 1'b1, 8'hA5);
    pulse(5); tick(3);
    wr_entry(5, 8'h35, 3'b001, 1'b1, 1'b0, 1'b0, 8'hA5);
    tick(6);
    chk(rec_q.size() == 0, "R5 masked edge dropped", rec_q.size(), 0);
    clearq();

    // R3: input 0 acts on pin 2
    wr_entry(0, 8'h10, 3'b000, 1'b0, 1'b0, 1'b0, 8'h00);
    wr_entry(2, 8'h22, 3'b000, 1'b0, 1'b0, 1'b0, 8'h02);
    pulse(0); tick(8);
    chk(rec_q.size() == 1, "R3 fold count", rec_q.size(), 1);
    if (rec_q.size() > 0)
      chk(rec_q[0][7:0] == 8'h22, "R3 fold vector", 32'(rec_q[0][7:0]), 32'h22);
    clearq();

    // R6 + R7: level handshake
    wr_entry(7, 8'h47, 3'b000, 1'b0, 1'b1, 1'b0, 8'h07);
    pin_in[7] = 1'b1; tick(10);
    chk(rec_q.size() == 1, "R6 level once", rec_q.size(), 1);
    if (rec_q.size() > 0)
      chk(rec_q[0][8] == 1'b1, "R6 level trig bit", 32'(rec_q[0][8]), 1);
    eoi(8'h48); tick(6);
    chk(rec_q.size() == 1, "R7 other vector ignored", rec_q.size(), 1);
    eoi(8'h47); tick(6);
    chk(rec_q.size() == 2, "R7 matching eoi redelivers", rec_q.size(), 2);
    pin_in[7] = 1'b0; tick(2);
    eoi(8'h47); tick(6);
    chk(rec_q.size() == 2, "R6 deassert clears pending", rec_q.size(), 2);
    clearq();

    // R11: masked level pin, unmask by write
    wr_entry(9, 8'h49, 3'b000, 1'b0, 1'b1, 1'b1, 8'h09);
    pin_in[9] = 1'b1; tick(6);
    chk(rec_q.size() == 0, "R11 masked level held", rec_q.size(), 0);
    wr_entry(9, 8'h49, 3'b000, 1'b0, 1'b1, 1'b0, 8'h09);
    tick(6);
    chk(rec_q.size() == 1, "R11 unmask delivers", rec_q.size(), 1);
    pin_in[9] = 1'b0; tick(2);
    clearq();

    // R10: external vector mode
    wr_entry(11, 8'h00, 3'b111, 1'b0, 1'b0, 1'b0, 8'h0B);
    pulse(11); tick(8);
    chk(rec_q.size() == 1 && rec_q[0][7:0] == 8'h9C, "R10 external vector",
        rec_q.size() > 0 ? 32'(rec_q[0][7:0]) : 32'hFFFF, 32'h9C);
    clearq();

    // R8: ascending order, back to back
    wr_entry(4, 8'h64, 3'b000, 1'b0, 1'b0, 1'b0, 8'h04);
    wr_entry(12, 8'h6C, 3'b000, 1'b0, 1'b0, 1'b0, 8'h0C);
    wr_entry(20, 8'h74, 3'b000, 1'b0, 1'b0, 1'b0, 8'h14);
    pin_in[4] = 1'b1; pin_in[12] = 1'b1; pin_in[20] = 1'b1; tick();
    pin_in = '0; tick(8);
    chk(rec_q.size() == 3, "R8 count", rec_q.size(), 3);
    if (rec_q.size() == 3) begin
      chk(rec_q[0][7:0] == 8'h64 && rec_q[1][7:0] == 8'h6C && rec_q[2][7:0] == 8'h74,
          "R8 order", {rec_q[0][7:0], rec_q[1][7:0], rec_q[2][7:0]}, 32'h646C74);
      chk(stamp_q[1] == stamp_q[0] + 1 && stamp_q[2] == stamp_q[1] + 1,
          "R8 one per cycle", stamp_q[2] - stamp_q[0], 2);
    end
    clearq();

    // R9: stall holds the message
    msg_ready = 1'b0;
    pin_in[4] = 1'b1; pin_in[12] = 1'b1; tick(); pin_in = '0;
    tick(4);
    chk(msg_valid && msg_vector == 8'h64, "R9 stalled message", 32'(msg_vector), 32'h64);
    tick(5);
    chk(msg_valid && msg_vector == 8'h64, "R9 still held", 32'(msg_vector), 32'h64);
    msg_ready = 1'b1; tick(6);
    chk(rec_q.size() == 2 && rec_q[1][7:0] == 8'h6C, "R9 release order",
        rec_q.size(), 2);
    clearq();

    // R12: delivery and matching eoi in the same cycle
    wr_entry(3, 8'h33, 3'b000, 1'b0, 1'b0, 1'b0, 8'h03);
    wr_entry(14, 8'h5E, 3'b000, 1'b0, 1'b1, 1'b0, 8'h0E);
    msg_ready = 1'b0;
    pulse(3); tick(4);
    pin_in[14] = 1'b1; tick(3);
    msg_ready = 1'b1; eoi_valid = 1'b1; eoi_vector = 8'h5E;
    tick();
    eoi_valid = 1'b0;
    tick(10);
    chk(rec_q.size() == 2, "R12 no second delivery", rec_q.size(), 2);
    if (rec_q.size() == 2)
      chk(rec_q[1][7:0] == 8'h5E, "R12 level vector", 32'(rec_q[1][7:0]), 32'h5E);
    eoi(8'h5E); tick(6);
    chk(rec_q.size() == 3, "R12 later eoi releases", rec_q.size(), 3);
    pin_in[14] = 1'b0; tick(2);
    clearq();

    // R4 + R8 random: bursts of edges on pins 3..10 with random back-pressure
    for (int p = 3; p <= 10; p++)
      wr_entry(p, 8'(8'h80 + p), 3'b000, 1'b0, 1'b0, 1'b0, 8'(p));
    tick(4);
    clearq();
    for (int r = 0; r < 30; r++) begin
      logic [7:0] bits;
      int         nexp;
      bit         ok;
      bits = 8'($urandom);
      nexp = $countones(bits);
      pin_in[10:3] = bits; tick(); pin_in = '0;
      for (int c = 0; c < 20; c++) begin
        msg_ready = 1'($urandom);
        tick();
      end
      msg_ready = 1'b1; tick(12);
      ok = (rec_q.size() == nexp);
      chk(ok, "R4 random count", rec_q.size(), nexp);
      if (ok) begin
        for (int k = 0; k < nexp; k++)
          chk(rec_q[k][7:0] == 8'(8'h83 + nth_set(bits, k)), "R8 random order",
              32'(rec_q[k][7:0]), 32'(8'h83 + nth_set(bits, k)));
      end
      clearq();
    end

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule